// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a single-ported synchronous SRAM. It has a burst address sequencer, byte-masked writes and a flow-through read path. All addresses, chip enables, burst strobes, write controls and write data are captured on the rising clock edge. Read data comes straight out of the array for the address captured at the last edge. The first beat of a burst therefore takes one address cycle plus the access, and each later beat takes one cycle (2-1-1-1).

A burst can be opened by either of two address strobes. The processor-side strobe `adsp_ni` is honoured only while `ce1_ni` is low, and its edge is always a read. The controller-side strobe `adsc_ni` is always honoured. Follow-on addresses come from a 2-bit beat counter that moves only on edges where `adv_ni` is low. The two low address bits step through the beats in linear or interleaved order, and the upper bits stay fixed. A burst does not have to be used: a new address can be strobed on every edge.

The shared data bus is split into `d_i`, `q_o` and the pad enable `q_en_o`. The bidirectional buffer sits in the pad ring. Output enable and sleep act on `q_en_o` without waiting for a clock. Tie `lin_mode_i` low to get interleaved order, which is the safe default for an undriven mode strap.

Top module: `ft_burst_sram`

## Requirements
- R1: After reset `q_en_o` is 0 and `q_o` is 0 until a read edge occurs.
- R2: An edge with a burst start (`adsc_ni` low, or `adsp_ni` low with `ce1_ni` low), the chip selected and no write active is a read. Through the following cycle `q_en_o` is 1 and `q_o` holds the word at the captured address. A new address may be started on every edge.
- R3: The chip is selected at a burst start only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. A deselected access neither writes nor drives `q_en_o`.
- R4: While `ce1_ni` is 1, a low `adsp_ni` starts nothing: the current address and read data are kept.
- R5: An edge started by `adsp_ni` is a read whatever the write controls are. A write on the next edge without `adv_ni` stores to that same address.
- R6: On an edge with no start, the burst address moves to the next beat only if `adv_ni` is 0. Otherwise it holds.
- R7: With `lin_mode_i`=1 (linear), beat n has address bits [1:0] equal to (start[1:0] + n) mod 4 and the upper bits of the start address. Beat 4 wraps back to the start.
- R8: With `lin_mode_i`=0 (interleaved), beat n has address bits [1:0] equal to start[1:0] XOR n, with the upper bits unchanged.
- R9: With `bwe_ni`=0 and `gwe_ni`=1, the edge writes exactly those bytes b whose `bsel_ni[b]` is 0. Byte b is `d_i[9b+8:9b]`.
- R10: With `gwe_ni`=0, all bytes are written whatever `bwe_ni` and `bsel_ni` are, and `q_en_o` is 0 in the following cycle.
- R11: An edge with `gwe_ni`=1 and either `bwe_ni`=1 or `bsel_ni` all ones writes nothing and is a read.
- R12: `oe_ni`=1 forces `q_en_o` to 0 at once, without a clock edge. `q_en_o` comes back when `oe_ni` returns to 0.
- R13: While `sleep_i` is 1, `q_en_o` is 0, clock edges change neither the array nor the burst state, and both are intact on wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address captured at a burst start |
| ce1_ni | input | 1 | Chip enable 1, active low; also gates `adsp_ni` |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| adsp_ni | input | 1 | Processor-side address strobe, active low |
| adsc_ni | input | 1 | Controller-side address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| gwe_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| bsel_ni | input | NBYTES | Per-byte select, active low |
| d_i | input | NBYTES*BYTE_W | Write data from the shared bus |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep, active high |
| lin_mode_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| q_o | output | NBYTES*BYTE_W | Read data, zero when not driving |
| q_en_o | output | 1 | Pad drive enable for the shared bus |

## Verification
The whole 64-word array is filled with global writes and then read back one new address per edge, which separates the flow-through read path from address-capture faults. Bursts are opened at every start address in both orders, with a held beat and a fifth beat added. These sweeps tell linear from interleaved stepping, prove the upper bits stay fixed and show the counter wraps. All 16 byte-select patterns are merged into one word, and all 8 chip-enable combinations are tried for writes and reads, so a wrong lane or a wrong select term gives a wrong readback. Separate sequences cover ADSP gating and forced reads, and apply output enable and sleep in the middle of a read without a clock.

// File: rtl/ftb_pkg.sv
`timescale 1ns/1ps
package ftb_pkg;
  localparam int BURST_W = 2;

  // low address bits for beat n of a burst
  function automatic logic [BURST_W-1:0] beat_lsb(input logic [BURST_W-1:0] start,
                                                  input logic [BURST_W-1:0] n,
                                                  input logic lin);
    return lin ? BURST_W'(start + n) : (start ^ n);
  endfunction
endpackage

// File: rtl/ftb_burst_seq.sv
`timescale 1ns/1ps
module ftb_burst_seq
  import ftb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load_i) begin
      base_d = ld_addr_i;
      cnt_d  = '0;
    end else if (adv_i) begin
      cnt_d = cnt_q + BURST_W'(1);
    end
  end

  assign acc_addr_o = {base_d[ADDR_W-1:BURST_W], beat_lsb(base_d[BURST_W-1:0], cnt_d, lin_i)};
  assign cur_addr_o = {base_q[ADDR_W-1:BURST_W], beat_lsb(base_q[BURST_W-1:0], cnt_q, lin_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (!hold_i) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/ftb_wr_mask.sv
`timescale 1ns/1ps
module ftb_wr_mask #(
  parameter int NBYTES = 4
) (
  input  logic              gw_ni,
  input  logic              bw_ni,
  input  logic [NBYTES-1:0] bsel_ni,
  output logic [NBYTES-1:0] mask_o
);
  always_comb begin
    if (!gw_ni)      mask_o = '1;       // global write overrides lanes
    else if (!bw_ni) mask_o = ~bsel_ni;
    else             mask_o = '0;
  end
endmodule

// File: rtl/ftb_mem.sv
`timescale 1ns/1ps
module ftb_mem #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [NBYTES-1:0]        mask_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[g]) lane_q[waddr_i] <= wdata_i[g*BYTE_W +: BYTE_W];
    end

    assign rdata_o[g*BYTE_W +: BYTE_W] = lane_q[raddr_i];
  end
endmodule

// File: rtl/ft_burst_sram.sv
`timescale 1ns/1ps
module ft_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     ce1_ni,
  input  logic                     ce2_i,
  input  logic                     ce3_ni,
  input  logic                     adsp_ni,
  input  logic                     adsc_ni,
  input  logic                     adv_ni,
  input  logic                     gwe_ni,
  input  logic                     bwe_ni,
  input  logic [NBYTES-1:0]        bsel_ni,
  input  logic [NBYTES*BYTE_W-1:0] d_i,
  input  logic                     oe_ni,
  input  logic                     sleep_i,
  input  logic                     lin_mode_i,
  output logic [NBYTES*BYTE_W-1:0] q_o,
  output logic                     q_en_o
);
  localparam int WORD_W = NBYTES * BYTE_W;

  logic              chip_on, adsp_go, start, adv;
  logic              sel_q, sel_d, rd_q, wr_req, wr_en;
  logic [NBYTES-1:0] wmask;
  logic [ADDR_W-1:0] acc_addr, cur_addr;
  logic [WORD_W-1:0] rdata;

  assign chip_on = !ce1_ni && ce2_i && !ce3_ni;
  assign adsp_go = !adsp_ni && !ce1_ni;
  assign start   = adsp_go || !adsc_ni;
  assign adv     = !start && !adv_ni;

  ftb_wr_mask #(.NBYTES(NBYTES)) u_mask (
    .gw_ni  (gwe_ni),
    .bw_ni  (bwe_ni),
    .bsel_ni(bsel_ni),
    .mask_o (wmask)
  );

  // processor-strobe starts are reads; chip enables only sampled at a start
  assign wr_req = (|wmask) && !adsp_go;
  assign sel_d  = start ? chip_on : sel_q;
  assign wr_en  = sel_d && wr_req && !sleep_i;

  ftb_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (sleep_i),
    .load_i    (start),
    .adv_i     (adv),
    .lin_i     (lin_mode_i),
    .ld_addr_i (addr_i),
    .acc_addr_o(acc_addr),
    .cur_addr_o(cur_addr)
  );

  ftb_mem #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .mask_i (wmask),
    .waddr_i(acc_addr),
    .wdata_i(d_i),
    .raddr_i(cur_addr),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
    end else if (!sleep_i) begin
      sel_q <= sel_d;
      rd_q  <= !wr_req;
    end
  end

  // flow-through: array output for the registered address, gated asynchronously
  assign q_en_o = sel_q && rd_q && !oe_ni && !sleep_i;
  assign q_o    = q_en_o ? rdata : '0;
endmodule

// File: rtl/ft_burst_sram_chk.sv
`timescale 1ns/1ps
module ft_burst_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce1_ni,
  input logic              ce2_i,
  input logic              adsp_ni,
  input logic              adsc_ni,
  input logic              adv_ni,
  input logic              gwe_ni,
  input logic              oe_ni,
  input logic              sleep_i,
  input logic              lin_mode_i,
  input logic              q_en_i,
  input logic [ADDR_W-1:0] cur_addr_i
);
  logic no_start;
  assign no_start = adsc_ni && (adsp_ni || ce1_ni);

  AST_DESEL_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !adsc_ni && !ce2_i) |=> !q_en_i); // R3

  AST_ADSP_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && adsc_ni && ce1_ni && !adsp_ni && adv_ni) |=>
      ($past(lin_mode_i) != lin_mode_i) || $stable(cur_addr_i)); // R4

  AST_HOLD_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && no_start && adv_ni) |=>
      ($past(lin_mode_i) != lin_mode_i) || $stable(cur_addr_i)); // R6

  AST_LIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && no_start && !adv_ni && lin_mode_i) |=>
      !lin_mode_i ||
      ((cur_addr_i[1:0] == 2'($past(cur_addr_i[1:0]) + 2'd1)) &&
       (cur_addr_i[ADDR_W-1:2] == $past(cur_addr_i[ADDR_W-1:2])))); // R7

  AST_GW_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !adsc_ni && (adsp_ni || ce1_ni) && !gwe_ni) |=> !q_en_i); // R10

  AST_OE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !q_en_i); // R12

  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !q_en_i); // R13

  AST_SLEEP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($past(lin_mode_i) != lin_mode_i) || $stable(cur_addr_i)); // R13
endmodule

bind ft_burst_sram ft_burst_sram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce1_ni    (ce1_ni),
  .ce2_i     (ce2_i),
  .adsp_ni   (adsp_ni),
  .adsc_ni   (adsc_ni),
  .adv_ni    (adv_ni),
  .gwe_ni    (gwe_ni),
  .oe_ni     (oe_ni),
  .sleep_i   (sleep_i),
  .lin_mode_i(lin_mode_i),
  .q_en_i    (q_en_o),
  .cur_addr_i(cur_addr)
);

// File: tb/ft_burst_sram_tb_top.sv
`timescale 1ns/1ps
module ft_burst_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int W  = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic          gwe_n = 1'b1, bwe_n = 1'b1;
  logic [NB-1:0] bsel_n = '1;
  logic [W-1:0]  d = '0;
  logic          oe_n = 1'b0, sleep = 1'b0, lin = 1'b0;
  logic [W-1:0]  q;
  logic          q_en;

  logic [W-1:0]  mdl [DEPTH];
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ft_burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n),
    .adsp_ni(adsp_n), .adsc_ni(adsc_n), .adv_ni(adv_n),
    .gwe_ni(gwe_n), .bwe_ni(bwe_n), .bsel_ni(bsel_n), .d_i(d),
    .oe_ni(oe_n), .sleep_i(sleep), .lin_mode_i(lin),
    .q_o(q), .q_en_o(q_en)
  );

  function automatic logic [W-1:0] pat(input int k);
    return W'(k * 36'h1_0F1E_2D3) ^ 36'hA_5A5A_5A5A;
  endfunction

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] s, input int n, input logic l);
    logic [1:0] lo;
    lo = l ? 2'(int'(s[1:0]) + n) : (s[1:0] ^ 2'(n));
    return {s[AW-1:2], lo};
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gwe_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
  endtask

  task automatic wr_gw(input int a, input logic [W-1:0] v);
    idle(); adsc_n = 1'b0; gwe_n = 1'b0; addr = AW'(a); d = v;
    tick(); idle();
    mdl[a] = v;
    check("R10 write no drive", W'(q_en), W'(0));
  endtask

  task automatic rd(input int a, input string req);
    idle(); adsc_n = 1'b0; addr = AW'(a);
    tick(); idle();
    check(req, W'(q_en), W'(1));
    check(req, q, mdl[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    check("R1 reset en", W'(q_en), W'(0));
    check("R1 reset data", q, '0);

    // fill, then read back one address per edge
    for (int a = 0; a < DEPTH; a++) wr_gw(a, pat(a));
    for (int a = 0; a < DEPTH; a++) rd(a, "R2 read");

    // bursts at every start in both orders
    for (int l = 0; l < 2; l++) begin
      lin = l[0];
      for (int s = 0; s < DEPTH; s++) begin
        rd(s, "R2 beat0");
        for (int n = 1; n < 5; n++) begin
          adv_n = 1'b0; tick(); idle();
          check(l ? "R7 linear beat" : "R8 interleaved beat", q, mdl[beat(AW'(s), n, lin)]);
          if (n == 1 && s[0] == 1'b0) begin
            tick();
            check("R6 hold without adv", q, mdl[beat(AW'(s), 1, lin)]);
          end
        end
      end
    end

    // burst writes in both orders
    for (int l = 0; l < 2; l++) begin
      int s;
      s = l ? 6 : 9;
      lin = l[0];
      idle(); adsc_n = 1'b0; gwe_n = 1'b0; addr = AW'(s); d = pat(300 + 4 * l);
      tick(); mdl[s] = pat(300 + 4 * l);
      for (int n = 1; n < 4; n++) begin
        idle(); adv_n = 1'b0; gwe_n = 1'b0; d = pat(300 + 4 * l + n);
        tick(); mdl[beat(AW'(s), n, lin)] = pat(300 + 4 * l + n);
      end
      idle();
      for (int n = 0; n < 4; n++) rd(int'(beat(AW'(s), n, lin)), l ? "R7 burst write" : "R8 burst write");
    end

    // processor strobe is a read; next held edge writes
    idle(); adsp_n = 1'b0; gwe_n = 1'b0; addr = AW'(20); d = pat(500);
    tick(); idle();
    check("R5 adsp forced read en", W'(q_en), W'(1));
    check("R5 adsp forced read data", q, mdl[20]);
    gwe_n = 1'b0; d = pat(501); tick(); idle(); mdl[20] = pat(501);
    rd(20, "R5 write after adsp");

    // byte lanes, every select pattern
    for (int p = 0; p < 16; p++) begin
      logic [W-1:0] v;
      v = pat(100 + p);
      idle(); adsc_n = 1'b0; bwe_n = 1'b0; bsel_n = NB'(p); addr = AW'(40); d = v;
      tick(); idle();
      for (int b = 0; b < NB; b++)
        if (!p[b]) mdl[40][b*BW +: BW] = v[b*BW +: BW];
      rd(40, "R9 byte merge");
    end
    idle(); adsc_n = 1'b0; bsel_n = '0; addr = AW'(40); d = pat(150);
    tick(); idle();
    check("R11 no bwe is read", q, mdl[40]);
    idle(); adsc_n = 1'b0; gwe_n = 1'b0; bwe_n = 1'b0; bsel_n = 4'b1110; addr = AW'(41); d = pat(151);
    tick(); idle(); mdl[41] = pat(151);
    rd(41, "R10 global overrides lanes");

    // chip-enable combinations
    for (int c = 0; c < 8; c++) begin
      ce1_n = c[0]; ce2 = c[1]; ce3_n = c[2];
      idle(); adsc_n = 1'b0; gwe_n = 1'b0; addr = AW'(50); d = pat(200 + c);
      tick(); idle();
      if (c == 2) mdl[50] = pat(200 + c);
      adsc_n = 1'b0; addr = AW'(51);
      tick(); idle();
      check("R3 select read", W'(q_en), W'(c == 2));
      ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
      rd(50, "R3 select write");
    end

    // processor strobe gated by ce1
    rd(12, "R2 read");
    ce1_n = 1'b1; adsp_n = 1'b0; addr = AW'(13);
    tick(); idle(); ce1_n = 1'b0;
    check("R4 adsp ignored en", W'(q_en), W'(1));
    check("R4 adsp ignored data", q, mdl[12]);
    adsp_n = 1'b0; addr = AW'(13); tick(); idle();
    check("R2 adsp read", q, mdl[13]);

    // asynchronous output enable
    oe_n = 1'b1; #1;
    check("R12 oe off", W'(q_en), W'(0));
    oe_n = 1'b0; #1;
    check("R12 oe on", q, mdl[13]);

    // sleep
    sleep = 1'b1; #1;
    check("R13 sleep quiet", W'(q_en), W'(0));
    adsc_n = 1'b0; gwe_n = 1'b0; addr = AW'(14); d = pat(900);
    tick();
    check("R13 sleep quiet edge", W'(q_en), W'(0));
    addr = AW'(13); tick(); idle();
    sleep = 1'b0; #1;
    check("R13 wake en", W'(q_en), W'(1));
    check("R13 wake state", q, mdl[13]);
    rd(14, "R13 array kept");
    rd(13, "R13 array kept");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule